// File: doc/BRIEF.md
# Dual-Function Edge Select Controller

This block serves one external timer input pin that drives two separate consumers: an external event counter and a capture unit. A small 8-bit control register holds two 2-bit edge-select fields, one for each consumer. The block brings the asynchronous pin into the clock domain, finds the edges chosen by each field, and produces a one-clock event strobe and a one-clock capture-trigger strobe.

The event path only fires when the external-event enable is high or the timer's 3-bit mode input carries the event-count code. While the timer's count-enable is high, the edge fields are frozen. A write that would change them is dropped and raises a sticky error flag. Software loads the register with byte writes, or with single-bit writes that carry a bit index and a bit value, and reads it back at any time.

Top module: `edgesel_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data` is 0x00, `lock_err` is 0, and neither strobe is asserted.
- R2: `rd_data[7:4]` always reads zero, whatever was written to those bits. `rd_data[3:2]` is the event edge field and `rd_data[1:0]` is the capture-trigger edge field.
- R3: With `cnt_en` low, a byte write (`wr_en`) loads `wr_data[3:0]` into bits 3:0, visible on `rd_data` after the next rising clock edge. A bit write (`bit_wr_en`) sets bit `bit_idx` to `bit_val`. A bit write to an index of 4 or more changes nothing. If both writes arrive in the same cycle, the byte write wins.
- R4: With `cnt_en` high, a write whose resulting bits 3:0 differ from the stored value leaves the register unchanged.
- R5: `lock_err` sets on a write that R4 blocks. A write with `cnt_en` high whose bits 3:0 match the stored value leaves `lock_err` unchanged. Any write with `cnt_en` low clears `lock_err`.
- R6: The edge field encoding is 00 for no detection, 01 for rising edges, 10 for falling edges and 11 for both. For each qualifying pin edge, `trig_pulse` is high for exactly one cycle. Take the clock edge that first samples the new pin level: the strobe starts at the second clock edge after it. The field value used is the one stored before that strobe edge.
- R7: `evt_pulse` follows the same encoding and timing using bits 3:2. It is only produced when, at the strobe edge, `evt_en` is 1 or `timer_mode` equals 3'b001.
- R8: If the pin holds a steady level, high or low, through reset, no strobe is produced after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external timer pin |
| cnt_en | input | 1 | Timer count-enable; locks the edge fields when high |
| evt_en | input | 1 | External-event enable for the event path |
| timer_mode | input | 3 | Timer mode; 3'b001 selects event counting |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 8 | Register read-back |
| lock_err | output | 1 | Sticky blocked-write flag |
| evt_pulse | output | 1 | One-cycle external event strobe |
| trig_pulse | output | 1 | One-cycle capture-trigger strobe |

## Verification
The hardest case to reach from the ports has three conditions at once: a pin edge reaches the detector in the same cycle that a field write or a gate change lands, so the old and new settings would give different strobes. Random stimulus toggles the pin, the gate inputs and both write kinds every cycle. The bench keeps a history of the pin samples, the gate inputs and the register value from before each edge, which lets it check the strobes against that overlap on every cycle. Directed steps cover the rest: both reset levels of the pin, same-value and differing writes under count-enable, and bit writes to the fixed-zero bits.

// File: rtl/edgesel_pkg.sv
package edgesel_pkg;

    localparam int FIELD_W   = 2;
    localparam int NUM_PATHS = 2;
    localparam int LIVE_W    = FIELD_W * NUM_PATHS;
    localparam int PATH_TRIG = 0;
    localparam int PATH_EVT  = 1;

    typedef enum logic [FIELD_W-1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic [LIVE_W-1:0] fields;
        logic              lock_err;
    } cfg_state_t;

endpackage

// File: rtl/edgesel_sync.sv
module edgesel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic cur,
    output logic prev
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            // preload every stage with the live pin so no edge is seen at release
            st_d.chain = {STAGES{pin_in}};
            st_d.prev  = pin_in;
        end else begin
            st_d.chain = {st_q.chain[LAST-1:0], pin_in};
            st_d.prev  = st_q.chain[LAST];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur  = st_q.chain[LAST];
    assign prev = st_q.prev;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur == prev)); // R8

endmodule

// File: rtl/edgesel_qual.sv
module edgesel_qual
    import edgesel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] sel,
    input  logic               enable,
    input  logic               cur,
    input  logic               prev,
    output logic               strobe
);
    logic strobe_d, strobe_q;
    logic rise, fall, hit;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (edge_sel_e'(sel))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        strobe_d = rst ? 1'b0 : (hit & enable);
    end

    always_ff @(posedge clk) begin
        strobe_q <= strobe_d;
    end

    assign strobe = strobe_q;

    AST_STROBE_HAS_EDGE: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> $past(cur != prev)); // R6
    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> ($past(sel) != EDGE_NONE)); // R6

endmodule

// File: rtl/edgesel_cfg_reg.sv
module edgesel_cfg_reg
    import edgesel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_wr_en,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    output logic [DATA_W-1:0] rd_data,
    output logic [LIVE_W-1:0] fields,
    output logic              lock_err
);
    localparam int PAD_W = DATA_W - LIVE_W;

    cfg_state_t        st_d, st_q;
    logic [DATA_W-1:0] cur_full;
    logic [DATA_W-1:0] cand;
    logic              any_wr;
    logic              changes;

    always_comb begin
        st_d     = st_q;
        cur_full = {{PAD_W{1'b0}}, st_q.fields};
        cand     = cur_full;
        if (wr_en) begin
            cand = wr_data;
        end else begin
            cand[bit_idx] = bit_val;
        end
        any_wr  = wr_en | bit_wr_en;
        changes = (cand[LIVE_W-1:0] != st_q.fields);

        if (rst) begin
            st_d.fields   = '0;
            st_d.lock_err = 1'b0;
        end else if (any_wr) begin
            if (!cnt_en) begin
                st_d.fields   = cand[LIVE_W-1:0];
                st_d.lock_err = 1'b0;
            end else if (changes) begin
                st_d.lock_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data  = {{PAD_W{1'b0}}, st_q.fields};
    assign fields   = st_q.fields;
    assign lock_err = st_q.lock_err;

    AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> (st_q.fields == $past(st_q.fields))); // R4
    AST_ERR_ON_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && wr_en && (wr_data[LIVE_W-1:0] != st_q.fields)) |=> st_q.lock_err); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && (wr_en || bit_wr_en)) |=> !st_q.lock_err); // R5
    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && wr_en) |=> (st_q.fields == $past(wr_data[LIVE_W-1:0]))); // R3

endmodule

// File: rtl/edgesel_ctrl.sv
module edgesel_ctrl
    import edgesel_pkg::*;
#(
    parameter int              DATA_W      = 8,
    parameter int              MODE_W      = 3,
    parameter int              SYNC_STAGES = 2,
    parameter logic [MODE_W-1:0] EVT_MODE  = 3'b001,
    localparam int             IDX_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              cnt_en,
    input  logic              evt_en,
    input  logic [MODE_W-1:0] timer_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_wr_en,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    output logic [DATA_W-1:0] rd_data,
    output logic              lock_err,
    output logic              evt_pulse,
    output logic              trig_pulse
);
    logic [LIVE_W-1:0]    fields;
    logic                 pin_cur, pin_prev;
    logic                 evt_gate;
    logic [NUM_PATHS-1:0] path_en;
    logic [NUM_PATHS-1:0] strobes;

    edgesel_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bit_wr_en(bit_wr_en),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val),
        .rd_data  (rd_data),
        .fields   (fields),
        .lock_err (lock_err)
    );

    edgesel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_in(pin_in),
        .cur   (pin_cur),
        .prev  (pin_prev)
    );

    always_comb begin
        evt_gate           = evt_en | (timer_mode == EVT_MODE);
        path_en            = '1;
        path_en[PATH_EVT]  = evt_gate;
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        edgesel_qual u_qual (
            .clk   (clk),
            .rst   (rst),
            .sel   (fields[p*FIELD_W +: FIELD_W]),
            .enable(path_en[p]),
            .cur   (pin_cur),
            .prev  (pin_prev),
            .strobe(strobes[p])
        );
    end

    assign evt_pulse  = strobes[PATH_EVT];
    assign trig_pulse = strobes[PATH_TRIG];

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> $past(evt_en || (timer_mode == EVT_MODE))); // R7
    AST_UPPER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cnt_en) |=> (rd_data[DATA_W-1:LIVE_W] == '0)); // R2

endmodule

// File: tb/edgesel_ctrl_tb_top.sv
`timescale 1ns/1ps
module edgesel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_in = 1'b0;
    logic       cnt_en = 1'b0;
    logic       evt_en = 1'b0;
    logic [2:0] timer_mode = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_wr_en = 1'b0;
    logic [2:0] bit_idx = '0;
    logic       bit_val = 1'b0;
    logic [7:0] rd_data;
    logic       lock_err, evt_pulse, trig_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    edgesel_ctrl dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cnt_en(cnt_en), .evt_en(evt_en),
        .timer_mode(timer_mode), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .rd_data(rd_data), .lock_err(lock_err), .evt_pulse(evt_pulse),
        .trig_pulse(trig_pulse)
    );

    // model state
    logic [3:0] m_reg, reg_pre;
    logic       m_err, g_en, last_blocked;
    logic [3:0] hp;          // hp[0] = pin at latest edge
    int         since_rst;

    function automatic logic edge_hit(input logic [1:0] sel, input logic o, input logic n);
        case (sel)
            2'b01:   return (!o && n);
            2'b10:   return (o && !n);
            2'b11:   return (o != n);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic et, ee;
        string st, se;
        et = edge_hit(reg_pre[1:0], hp[3], hp[2]);
        ee = g_en && edge_hit(reg_pre[3:2], hp[3], hp[2]);
        st = (since_rst < 4) ? "R8" : "R6";
        se = (since_rst < 4) ? "R8" : "R7";
        chk(last_blocked ? "R4" : "R3", {4'b0, rd_data[3:0]}, {4'b0, m_reg});
        chk("R2", {4'b0, rd_data[7:4]}, 8'h00);
        chk("R5", {7'b0, lock_err}, {7'b0, m_err});
        chk(st, {7'b0, trig_pulse}, {7'b0, et});
        chk(se, {7'b0, evt_pulse}, {7'b0, ee});
        since_rst++;
    endtask

    task automatic step(input logic p, input logic ce, input logic ee, input logic [2:0] md,
                        input logic we, input logic [7:0] wd,
                        input logic bwe, input logic [2:0] bi, input logic bv);
        logic [7:0] cand;
        @(negedge clk);
        check_all();
        rst = 1'b0; pin_in = p; cnt_en = ce; evt_en = ee; timer_mode = md;
        wr_en = we; wr_data = wd; bit_wr_en = bwe; bit_idx = bi; bit_val = bv;
        // model the next rising edge
        reg_pre = m_reg;
        cand = {4'b0, m_reg};
        if (we) cand = wd;
        else    cand[bi] = bv;
        last_blocked = 1'b0;
        if (we || bwe) begin
            if (!ce) begin
                m_reg = cand[3:0];
                m_err = 1'b0;
            end else if (cand[3:0] != m_reg) begin
                m_err = 1'b1;
                last_blocked = 1'b1;
            end
        end
        hp = {hp[2:0], p};
        g_en = ee || (md == 3'b001);
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst = 1'b1; pin_in = lvl; cnt_en = 1'b0; wr_en = 1'b0; bit_wr_en = 1'b0;
        evt_en = 1'b1; timer_mode = 3'b001;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", rd_data, 8'h00);
            chk("R1", {6'b0, evt_pulse, trig_pulse}, 8'h00);
            chk("R1", {7'b0, lock_err}, 8'h00);
        end
        m_reg = '0; reg_pre = '0; m_err = 1'b0; g_en = 1'b1;
        hp = {4{lvl}}; since_rst = 0; last_blocked = 1'b0;
    endtask

    // idle cycle helper with the pin held
    task automatic hold(input logic p, input logic [2:0] md, input int n);
        for (int i = 0; i < n; i++) step(p, 1'b0, 1'b0, md, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0);
    endtask

    initial begin
        int seed;
        logic pv;
        seed = $urandom(32'd7719);

        // R8: reset with pin high, event gate open, all edges selected
        do_reset(1'b1);
        step(1'b1, 1'b0, 1'b1, 3'b001, 1'b1, 8'h0F, 1'b0, 3'd0, 1'b0);
        hold(1'b1, 3'b001, 6);

        // R6: trigger rising only, then toggle
        do_reset(1'b0);
        step(1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 8'hF1, 1'b0, 3'd0, 1'b0);
        hold(1'b1, 3'b000, 4);
        hold(1'b0, 3'b000, 4);
        // R6: falling, via bit writes; byte write wins over a bit write
        step(1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 8'h02, 1'b1, 3'd0, 1'b1);
        hold(1'b1, 3'b000, 4);
        hold(1'b0, 3'b000, 4);
        // R7: event both edges, gated off then via mode code
        step(1'b0, 1'b0, 1'b0, 3'b010, 1'b1, 8'h0C, 1'b0, 3'd0, 1'b0);
        hold(1'b1, 3'b010, 4);
        hold(1'b0, 3'b001, 4);
        // R4/R5: same-value write under count-enable, then a differing one
        step(1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 8'hAC, 1'b0, 3'd0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 8'h03, 1'b0, 3'd0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 3'd2, 1'b0);
        hold(1'b0, 3'b000, 2);
        // R3/R5: bit write to a fixed-zero bit clears the flag only
        step(1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 3'd6, 1'b1);
        hold(1'b0, 3'b000, 2);

        // random phase
        pv = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            logic ce, we, bwe;
            if ($urandom % 2 == 0) pv = ~pv;
            ce  = ($urandom % 4 == 0);
            we  = ($urandom % 6 == 0);
            bwe = ($urandom % 6 == 0);
            step(pv, ce, 1'($urandom), 3'($urandom), we, 8'($urandom),
                 bwe, 3'($urandom), 1'($urandom));
            if (n == 2000) begin
                do_reset(pv);
            end
        end
        @(negedge clk);
        check_all();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule